// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Timer

This block produces a single output pulse of programmable length each time an external trigger line falls. The trigger is brought into the system clock domain through a flop chain. Its falling edge, one clock wide, arms an internal run flag. From the next prescaler tick on, a counter steps upward. The step from 0 to 1 fires a set strobe, and the wrap from the compare value back to 0 fires a clear strobe. A separate set/clear flop forms the pulse output from these two strobes.

When the single-shot mode input is high, the wrap also drops the run flag. The block is then back in its idle state and waits for the next trigger edge. When the mode input is low, the run flag stays set and the counter keeps wrapping, so the output becomes a periodic pulse train. The prescaler tick is a one-clock strobe in the system clock domain, supplied by the surrounding logic, and the counter moves only in cycles where it is high.

Top module: `one_shot_timer`

## Requirements
- R1: The trigger passes through two synchronizing flops. A 1-to-0 transition of the synchronized trigger arms the run flag. Counting starts only at the first tick after the flag is set, so with the tick held high the output rises on the fifth clock edge after the trigger input falls.
- R2: While the synchronous reset is high and afterwards, the output is 0, and no pulse appears until a trigger edge arrives. A reset during a pulse drives the output low and disarms the block.
- R3: On the counter step from 0 to 1, a one-clock set strobe is asserted, and the output is 1 from the following clock edge.
- R4: At a tick where the counter equals the compare value, the counter returns to 0, a one-clock clear strobe is asserted, and the output is 0 from the next edge. For a compare value of N ≥ 1, the output stays high for exactly N tick periods.
- R5: When the mode input is 1, the wrap disarms the run flag. No further pulse appears until a new trigger edge.
- R6: Each later trigger edge after the block has returned to idle produces a pulse identical to the first.
- R7: The counter advances only in clock cycles where the tick input is 1, so the pulse length scales with the tick spacing.
- R8: A trigger edge that arrives while the run flag is set has no effect. The running pulse keeps its length and no extra pulse follows.
- R9: When the mode input is 0, the run flag stays set across wraps. The output repeats N tick periods high and one tick period low.
- R10: With a compare value of 0, no pulse is produced. In single-shot mode the first tick disarms the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger, idle high, acts on falling edge |
| oneshot_i | input | 1 | 1: stop after one pulse; 0: repeat |
| cmp_i | input | CNT_W | Compare value (pulse length in ticks) |
| tick_i | input | 1 | Prescaler count enable, one clock wide |
| pulse_o | output | 1 | Pulse output |

## Verification
The assertions assume that the compare value and the mode input change only while the block is idle or in reset. They also assume that the tick is a clean synchronous strobe and that reset is held for at least two clocks from time zero. The stimulus follows these rules: it reprograms compare, mode and tick spacing only between pulses or under reset, and it derives the tick from a free-running divider in the bench. It sends every trigger as a clean low level held for several clocks, so the asynchronous path is exercised only through the synchronizer as intended.

// File: rtl/ost_pkg.sv
package ost_pkg;

    // Strobe produced by the counter core toward the output flop
    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_SET  = 2'd1,
        STB_CLR  = 2'd2
    } stb_e;

endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic fall_o
);
    // chain[0..STAGES-1] synchronize; chain[STAGES] holds the previous value
    localparam int LAST = STAGES;

    logic [LAST:0] chain_d, chain_q;

    assign chain_d[0] = trig_i;

    generate
        for (genvar i = 1; i <= LAST; i++) begin : g_stage
            assign chain_d[i] = chain_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];
endmodule

// File: rtl/ost_count_core.sv
module ost_count_core
    import ost_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic             tick_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output stb_e             stb_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        stb_e             stb;
    } core_t;

    localparam core_t CORE_RST = '{cnt: '0, en: 1'b0, stb: STB_NONE};

    core_t core_d, core_q;
    logic  at_cmp;

    assign at_cmp = (core_q.cnt == cmp_i);

    always_comb begin
        core_d     = core_q;
        core_d.stb = STB_NONE;
        if (!core_q.en) begin
            if (fall_i) core_d.en = 1'b1;
        end else if (tick_i) begin
            if (at_cmp) begin
                core_d.cnt = '0;
                core_d.stb = STB_CLR;
                if (oneshot_i) core_d.en = 1'b0;
            end else begin
                core_d.cnt = core_q.cnt + 1'b1;
                if (core_q.cnt == '0) core_d.stb = STB_SET;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= CORE_RST;
        else     core_q <= core_d;
    end

    assign cnt_o = core_q.cnt;
    assign en_o  = core_q.en;
    assign stb_o = core_q.stb;
endmodule

// File: rtl/ost_sr_out.sv
module ost_sr_out
    import ost_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  stb_e stb_i,
    output logic pulse_o
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        unique case (stb_i)
            STB_SET: pulse_d = 1'b1;
            STB_CLR: pulse_d = 1'b0;
            default: pulse_d = pulse_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/one_shot_timer.sv
module one_shot_timer
    import ost_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             tick_i,
    output logic             pulse_o
);
    logic             trig_fall;
    logic [CNT_W-1:0] cnt_w;
    logic             en_w;
    stb_e             stb_w;
    logic             set_stb;
    logic             clr_stb;

    ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .fall_o (trig_fall)
    );

    ost_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .fall_i    (trig_fall),
        .tick_i    (tick_i),
        .oneshot_i (oneshot_i),
        .cmp_i     (cmp_i),
        .cnt_o     (cnt_w),
        .en_o      (en_w),
        .stb_o     (stb_w)
    );

    ost_sr_out u_out (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (stb_w),
        .pulse_o (pulse_o)
    );

    assign set_stb = (stb_w == STB_SET);
    assign clr_stb = (stb_w == STB_CLR);
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             oneshot_i,
    input logic [CNT_W-1:0] cmp_i,
    input logic             fall_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             en_i,
    input logic             set_i,
    input logic             clr_i,
    input logic             pulse_i
);
    AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!en_i && fall_i) |=> (en_i && cnt_i == '0)); // R1

    AST_SET_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        set_i |-> (cnt_i == CNT_W'(1) && $past(cnt_i) == '0)); // R3

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pulse_i); // R3

    AST_CLR_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        clr_i |-> (cnt_i == '0 && $past(cnt_i) == cmp_i)); // R4

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !pulse_i); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (cnt_i <= cmp_i)); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (cnt_i == '0)); // R5

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (en_i && tick_i && cnt_i == cmp_i && oneshot_i) |=> !en_i); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_i)); // R7

    AST_IGNORE_RETRIG: assert property (@(posedge clk) disable iff (rst)
        (en_i && fall_i && !(tick_i && cnt_i == cmp_i)) |=> (en_i && !set_i)); // R8

    AST_FREE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (en_i && tick_i && cnt_i == cmp_i && !oneshot_i) |=> en_i); // R9
endmodule

bind one_shot_timer ost_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .oneshot_i (oneshot_i),
    .cmp_i     (cmp_i),
    .fall_i    (trig_fall),
    .cnt_i     (cnt_w),
    .en_i      (en_w),
    .set_i     (set_stb),
    .clr_i     (clr_stb),
    .pulse_i   (pulse_o)
);

// File: tb/tb_one_shot_timer.sv
`timescale 1ns/1ps
module tb_one_shot_timer;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_i = 1'b1;
    logic             oneshot_i = 1'b1;
    logic [CNT_W-1:0] cmp_i = 16'd3;
    logic             tick_i = 1'b0;
    logic             pulse_o;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int tcnt = 0;
    bit finished = 0;

    // scoreboard state
    int exp_q[$];
    int rises = 0;
    int done = 0;
    int hi_len = 0;
    logic prev_p = 1'b0;
    string cur_tag = "R4";

    always #2 clk = ~clk;

    one_shot_timer #(.CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .oneshot_i (oneshot_i),
        .cmp_i     (cmp_i),
        .tick_i    (tick_i),
        .pulse_o   (pulse_o)
    );

    // tick divider, driven away from the active edge
    always @(negedge clk) begin
        if (tcnt >= div - 1) begin
            tcnt = 0;
            tick_i = 1'b1;
        end else begin
            tcnt = tcnt + 1;
            tick_i = (div == 1);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: measures each pulse in clocks and compares with the queue
    always @(negedge clk) begin
        if (rst) begin
            hi_len = 0;
            prev_p = 1'b0;
        end else begin
            if (pulse_o) begin
                if (!prev_p) rises++;
                hi_len++;
            end else if (prev_p) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected pulse"}, hi_len, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(hi_len == e, {cur_tag, " pulse width"}, hi_len, e);
                end
                done++;
                hi_len = 0;
            end
            prev_p = pulse_o;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    task automatic fire();
        @(negedge clk);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        trig_i = 1'b1;
    endtask

    task automatic wait_done(input int n, input string tag);
        int k;
        for (k = 0; k < 4000; k++) begin
            @(posedge clk);
            if (done >= n) break;
        end
        #1;
        chk(done >= n, {tag, " pulse completed"}, done, n);
    endtask

    task automatic idle_clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        int w;
        // R2: reset state
        repeat (4) @(negedge clk);
        chk(pulse_o == 1'b0, "R2 output low in reset", pulse_o, 0);
        rst = 1'b0;
        idle_clocks(50);
        @(posedge clk); #1;
        chk(rises == 0, "R2 no pulse without trigger", rises, 0);

        // R1/R3: latency with tick held high, compare 3
        cur_tag = "R4";
        div = 1; cmp_i = 16'd3; oneshot_i = 1'b1;
        idle_clocks(2);
        exp_q.push_back(3);
        @(negedge clk);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(pulse_o == 1'b0, "R1 no count in arming cycle", pulse_o, 0);
        @(negedge clk);
        chk(pulse_o == 1'b1, "R3 output high after 0->1 step", pulse_o, 1);
        trig_i = 1'b1;
        wait_done(1, "R4");
        idle_clocks(60);
        @(posedge clk); #1;
        chk(rises == 1, "R5 single pulse then idle", rises, 1);

        // R7: tick spacing 4, compare 5 -> 20 clocks
        div = 4; cmp_i = 16'd5;
        cur_tag = "R7";
        exp_q.push_back(20);
        fire();
        wait_done(2, "R7");

        // R6: later edge repeats the same pulse
        cur_tag = "R6";
        idle_clocks(10);
        exp_q.push_back(20);
        fire();
        wait_done(3, "R6");

        // R8: retrigger during a running pulse is ignored
        cur_tag = "R8";
        idle_clocks(10);
        cmp_i = 16'd6;
        base = rises;
        exp_q.push_back(24);
        fire();
        idle_clocks(8);
        fire();
        wait_done(4, "R8");
        idle_clocks(80);
        @(posedge clk); #1;
        chk(rises == base + 1, "R8 no extra pulse from retrigger", rises, base + 1);

        // R10: compare 0 gives no pulse and disarms
        cur_tag = "R10";
        cmp_i = 16'd0; div = 1;
        base = rises;
        fire();
        idle_clocks(60);
        @(posedge clk); #1;
        chk(rises == base, "R10 compare 0 no pulse", rises, base);
        cmp_i = 16'd2;
        exp_q.push_back(2);
        fire();
        wait_done(5, "R10");

        // R9: free-running train, compare 2 tick spacing 4
        cur_tag = "R9";
        idle_clocks(10);
        oneshot_i = 1'b0; div = 4;
        for (int i = 0; i < 4; i++) exp_q.push_back(8);
        fire();
        wait_done(9, "R9");
        @(negedge clk);
        rst = 1'b1;
        idle_clocks(3);
        chk(pulse_o == 1'b0, "R2 reset clears train", pulse_o, 0);
        chk(exp_q.size() == 0, "R9 all train pulses seen", exp_q.size(), 0);
        rst = 1'b0;
        oneshot_i = 1'b1;

        // R2: reset during a pulse disarms
        cur_tag = "R2";
        cmp_i = 16'd10;
        idle_clocks(5);
        fire();
        w = 0;
        while (pulse_o !== 1'b1 && w < 200) begin
            @(negedge clk);
            w++;
        end
        chk(pulse_o == 1'b1, "R2 pulse started before reset", pulse_o, 1);
        rst = 1'b1;
        idle_clocks(2);
        chk(pulse_o == 1'b0, "R2 reset drops output", pulse_o, 0);
        rst = 1'b0;
        base = rises;
        idle_clocks(100);
        @(posedge clk); #1;
        chk(rises == base, "R2 disarmed after reset", rises, base);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule